// File: doc/BRIEF.md
# I2C Memory and Register Target

This block is a bus target for a two-wire serial bus with a clock line and an open-drain data line. It serves a 512-byte general-purpose memory and two single-byte registers: a control byte and a fault byte. The target answers three device-select codes. The ninth memory address bit travels inside the device-select byte. An internal address counter supplies the address whenever the master reads without sending a word address first.

Both bus lines are sampled with the system clock, which must run much faster than the bus clock. Start and stop conditions are recognised as data-line edges while the clock line is high. Received data is buffered until a stop arrives at a legal bit position. Only then is it committed, and only if the write-enable bit is set and the write-protect input is low. Control-register contents are changed through a three-step key sequence.

Top module: `i2c_memreg_target`

## Requirements
- R1: A device-select byte whose upper six bits are 101000 selects the memory; bit 1 of that byte is memory address bit 8, bit 0 is the read/write flag (1 = read). A write to address 0x0FE and a write to 0x1FE land in different bytes.
- R2: Device select 0xB2/0xB3 (1011001 plus R/W) selects the control byte, 0xB0/0xB1 (1011000 plus R/W) selects the fault byte; any other device-select byte is not acknowledged (data line left released in the ninth clock).
- R3: For either register the word address byte must be 0xFF; any other value is not acknowledged and the transaction has no effect on the register.
- R4: A random read (start, select with write, word address, repeated start, select with read, data, master NACK, stop) returns the byte stored at the given address.
- R5: In a sequential read the target returns bytes from successive addresses while the master acknowledges; the address counter wraps from 0x1FF to 0x000, also during page writes.
- R6: A read without a word address (current-address read) starts at the counter, which points one past the last byte transferred.
- R7: After reset the data line is released, the write-enable bit is 0, and memory writes are dropped even though their data bytes are acknowledged; the data line is driven only low and changes only after a falling clock edge.
- R8: Writing 0x02 to the control byte sets the write-enable bit; afterwards byte writes and page writes of up to 16 bytes are stored at incrementing addresses.
- R9: While the write-protect input is high, writes to the memory, the fault byte and the control byte (including key writes) are all dropped; data bytes are still acknowledged.
- R10: A write is committed only when stop is the first clocked event after the acknowledge of a complete data byte; a stop in the middle of a byte or a repeated start aborts the whole write.
- R11: The control byte takes a new value only on the write following a write of 0x06 made while write-enable is set; other control writes leave its value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| wp_i | input | 1 | Write protect; high blocks every write |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |

## Verification
The stop-position check and the enable/protect gating both decide at the same stop edge whether buffered bytes reach storage. The bench therefore sends otherwise well-formed writes with the protect input raised. It also sends writes with write-enable set whose stop comes mid-byte or is replaced by a repeated start, and reads every affected location back to confirm that nothing changed. The address counter advancing and wrapping from 0x1FF at the same byte as a page write is provoked by a five-byte write starting at 0x1FE. That case is judged by a sequential read over the wrap and a current-address read that follows it.

// File: rtl/i2c_mrt_pkg.sv
package i2c_mrt_pkg;
    localparam int MEM_AW = 9;
    localparam logic [5:0] SEL_MEM = 6'b101000;
    localparam logic [6:0] SEL_CTL = 7'b1011001;
    localparam logic [6:0] SEL_FLT = 7'b1011000;
    localparam logic [7:0] REG_WORD = 8'hFF;
    localparam logic [7:0] KEY_WEL = 8'h02;
    localparam logic [7:0] KEY_ARM = 8'h06;

    typedef enum logic [3:0] {
        S_IDLE, S_DEVSEL, S_ACK_DEV, S_WADDR, S_ACK_ADDR,
        S_WDATA, S_ACK_WDATA, S_RDATA, S_RACK, S_IGNORE, S_COMMIT
    } eng_state_e;

    typedef enum logic [1:0] {T_MEM, T_CTL, T_FLT} target_e;
endpackage

// File: rtl/i2c_mrt_linesync.sv
module i2c_mrt_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_o,
    output logic wp_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int N = SYNC_STAGES;

    typedef struct packed {
        logic [N:0]   scl;
        logic [N:0]   sda;
        logic [N-1:0] wp;
    } ls_t;

    ls_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[N-1:0], scl_i};
        d.sda = {q.sda[N-1:0], sda_i};
        d.wp  = {q.wp[N-2:0], wp_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = q.scl[N-1];
    assign scl_old = q.scl[N];
    assign sda_now = q.sda[N-1];
    assign sda_old = q.sda[N];

    assign sda_o      = sda_now;
    assign wp_o       = q.wp[N-1];
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

    // R10: bus events that steer the engine never coincide
    a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

// File: rtl/i2c_mrt_store.sv
module i2c_mrt_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_mrt_engine.sv
module i2c_mrt_engine
    import i2c_mrt_pkg::*;
#(
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda,
    input  logic              wp,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [MEM_AW-1:0] mem_raddr,
    output logic              sda_oe
);
    localparam int PG_W  = $clog2(PAGE_BYTES + 1);
    localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [PG_W-1:0] PAGE_LIM = PG_W'(PAGE_BYTES);

    typedef struct packed {
        eng_state_e                  st;
        target_e                     tgt;
        logic [3:0]                  bits;
        logic [7:0]                  sh;
        logic                        oe;
        logic                        rw;
        logic                        hi;
        logic                        more;
        logic [MEM_AW-1:0]           cnt;
        logic [MEM_AW-1:0]           wbase;
        logic [PAGE_BYTES-1:0][7:0]  wbuf;
        logic [PG_W-1:0]             wcnt;
        logic [PG_W-1:0]             cidx;
        logic                        ok;
        logic                        wel;
        logic                        armed;
        logic [7:0]                  ctl;
        logic [7:0]                  flt;
    } eng_t;

    eng_t q, d;
    logic [7:0] rd_byte;
    logic [7:0] reg_in;

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = q.wbase + MEM_AW'(q.cidx);
        mem_wdata = q.wbuf[q.cidx[IDX_W-1:0]];
        reg_in    = q.wbuf[0];
        case (q.tgt)
            T_CTL:   rd_byte = q.ctl;
            T_FLT:   rd_byte = q.flt;
            default: rd_byte = mem_rdata;
        endcase

        if (q.st == S_COMMIT) begin
            if (q.tgt == T_MEM) begin
                mem_we = q.ok;
                d.cidx = q.cidx + PG_W'(1);
                if (q.cidx + PG_W'(1) == q.wcnt) begin
                    d.st   = S_IDLE;
                    d.wcnt = '0;
                end
            end else begin
                if (q.ok) begin
                    if (q.tgt == T_FLT) begin
                        d.flt = reg_in;
                    end else if (q.armed) begin
                        d.ctl   = reg_in;
                        d.armed = 1'b0;
                    end else if (reg_in == KEY_WEL) begin
                        d.wel = 1'b1;
                    end else if (reg_in == KEY_ARM && q.wel) begin
                        d.armed = 1'b1;
                    end
                end
                d.st   = S_IDLE;
                d.wcnt = '0;
            end
        end else if (start_evt) begin
            d.st   = S_DEVSEL;
            d.bits = '0;
            d.oe   = 1'b0;
            d.wcnt = '0;
        end else if (stop_evt) begin
            d.oe = 1'b0;
            if (q.st == S_WDATA && q.bits == 4'd1 && q.wcnt != '0) begin
                d.st   = S_COMMIT;
                d.cidx = '0;
                d.ok   = ~wp & (q.wel | (q.tgt == T_CTL));
            end else begin
                d.st   = S_IDLE;
                d.wcnt = '0;
            end
        end else begin
            case (q.st)
                S_DEVSEL, S_WADDR, S_WDATA: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[6:0], sda};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        if (q.st == S_DEVSEL) begin
                            d.rw = q.sh[0];
                            d.hi = q.sh[1];
                            d.oe = 1'b1;
                            d.st = S_ACK_DEV;
                            if (q.sh[7:2] == SEL_MEM)      d.tgt = T_MEM;
                            else if (q.sh[7:1] == SEL_CTL) d.tgt = T_CTL;
                            else if (q.sh[7:1] == SEL_FLT) d.tgt = T_FLT;
                            else begin
                                d.oe = 1'b0;
                                d.st = S_IGNORE;
                            end
                        end else if (q.st == S_WADDR) begin
                            if (q.tgt != T_MEM && q.sh != REG_WORD) begin
                                d.st = S_IGNORE;
                            end else begin
                                d.oe = 1'b1;
                                d.st = S_ACK_ADDR;
                                if (q.tgt == T_MEM) begin
                                    d.cnt   = {q.hi, q.sh};
                                    d.wbase = {q.hi, q.sh};
                                end
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = S_ACK_WDATA;
                            if (q.wcnt < PAGE_LIM) begin
                                d.wbuf[q.wcnt[IDX_W-1:0]] = q.sh;
                                d.wcnt = q.wcnt + PG_W'(1);
                            end
                            if (q.tgt == T_MEM) d.cnt = q.cnt + MEM_AW'(1);
                        end
                    end
                end
                S_ACK_DEV: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.sh = {rd_byte[6:0], 1'b0};
                            d.oe = ~rd_byte[7];
                            d.st = S_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_WADDR;
                        end
                    end
                end
                S_ACK_ADDR, S_ACK_WDATA: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        d.st   = S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = S_RACK;
                            if (q.tgt == T_MEM) d.cnt = q.cnt + MEM_AW'(1);
                        end else begin
                            d.oe = ~q.sh[7];
                            d.sh = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        d.more = ~sda;
                    end else if (scl_fall) begin
                        if (q.more) begin
                            d.sh   = {rd_byte[6:0], 1'b0};
                            d.oe   = ~rd_byte[7];
                            d.bits = '0;
                            d.st   = S_RDATA;
                        end else begin
                            d.st = S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_raddr = q.cnt;
    assign sda_oe    = q.oe;

    // R7: the data driver only moves right after a falling bus clock
    a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(scl_fall));

    // R7, R8: no memory store without the enable latch
    a_r7_store_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> q.wel);

    // R10: commit phase is only entered on a stop event
    a_r10_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_COMMIT && $past(q.st) != S_COMMIT) |-> $past(stop_evt));

    // R9: a stop seen with protect high never arms a commit
    a_r9_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_COMMIT && $past(q.st) != S_COMMIT && $past(wp)) |-> !q.ok);

    // R3: register word address acknowledged only for the fixed value
    a_r3_reg_word_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ACK_ADDR && q.tgt != T_MEM) |-> (q.sh == REG_WORD));

    // R10: a start discards any buffered bytes
    a_r10_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && q.st != S_COMMIT) |=> (q.wcnt == '0));
endmodule

// File: rtl/i2c_memreg_target.sv
module i2c_memreg_target
    import i2c_mrt_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    logic              sda_s, wp_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_wdata, mem_rdata;

    i2c_mrt_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .wp_i       (wp_i),
        .sda_o      (sda_s),
        .wp_o       (wp_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_mrt_engine #(.PAGE_BYTES(PAGE_BYTES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda       (sda_s),
        .wp        (wp_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .sda_oe    (sda_oe_o)
    );

    i2c_mrt_store #(.ADDR_W(MEM_AW), .DATA_W(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );
endmodule

// File: tb/sim_i2c_memreg_target.sv
module sim_i2c_memreg_target;
    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    wire  oe;
    wire  bus_sda = sda_m & ~oe;

    always #4 clk = ~clk;

    i2c_memreg_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
        .wp_i(wp), .sda_oe_o(oe)
    );

    localparam logic [7:0] CTL_W = 8'hB2, FLT_W = 8'hB0, BAD_SEL = 8'hC0;

    int   checks = 0, failures = 0;
    bit   done = 1'b0;
    logic [7:0] wbytes [16];
    logic [7:0] rbytes [16];
    logic ack_dev, ack_wa, ack_data;

    function automatic logic [7:0] msel(input logic a8, input logic rd);
        return {6'b101000, a8, rd};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quarter; repeat (8) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1; quarter; scl_m = 1; quarter; sda_m = 0; quarter; scl_m = 0; quarter;
    endtask

    task automatic bus_stop;
        sda_m = 0; quarter; scl_m = 1; quarter; sda_m = 1; quarter;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; quarter; scl_m = 1; quarter; quarter; scl_m = 0; quarter;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1; quarter; scl_m = 1; quarter; b = bus_sda; quarter; scl_m = 0; quarter;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~mack);
    endtask

    task automatic write_txn(input logic [7:0] dev, input logic [7:0] wa, input int n);
        logic a;
        bus_start;
        send_byte(dev, ack_dev);
        send_byte(wa, ack_wa);
        ack_data = 1'b1;
        for (int i = 0; i < n; i++) begin
            send_byte(wbytes[i], a);
            ack_data &= a;
        end
        bus_stop;
    endtask

    task automatic read_txn(input logic [7:0] dev, input bit use_wa, input logic [7:0] wa, input int n);
        logic a;
        bus_start;
        if (use_wa) begin
            send_byte({dev[7:1], 1'b0}, a);
            send_byte(wa, ack_wa);
            bus_start;
        end
        send_byte({dev[7:1], 1'b1}, ack_dev);
        for (int i = 0; i < n; i++) recv_byte(rbytes[i], i != n - 1);
        bus_stop;
    endtask

    task automatic write1(input logic [7:0] dev, input logic [7:0] wa, input logic [7:0] v);
        wbytes[0] = v;
        write_txn(dev, wa, 1);
    endtask

    task automatic do_reset;
        rst_n = 0; repeat (10) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset;
        chk("R7 data line released after reset", oe, 0);
    endtask

    task automatic t_enable_and_store;
        write1(CTL_W, 8'hFF, 8'h02);
        chk("R2 control select acknowledged", ack_dev, 1);
        write1(msel(0, 0), 8'h10, 8'hA5);
        chk("R8 data acknowledged", ack_data, 1);
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R4 random read after enabled write", rbytes[0], 8'hA5);
    endtask

    task automatic t_wel_clear_on_reset;
        do_reset;
        write1(msel(0, 0), 8'h10, 8'h11);
        chk("R7 dropped write still acknowledged", ack_data, 1);
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R7 write dropped while enable clear", rbytes[0], 8'hA5);
        write1(CTL_W, 8'hFF, 8'h02);
    endtask

    task automatic t_select_codes;
        write1(BAD_SEL, 8'h00, 8'h00);
        chk("R2 foreign select not acknowledged", ack_dev, 0);
        write1(FLT_W, 8'hFF, 8'h3C);
        read_txn(FLT_W, 1, 8'hFF, 1);
        chk("R2 fault byte random read", rbytes[0], 8'h3C);
        read_txn(FLT_W, 0, 8'h00, 1);
        chk("R2 fault byte current read", rbytes[0], 8'h3C);
    endtask

    task automatic t_reg_word;
        write1(FLT_W, 8'h00, 8'h55);
        chk("R3 bad register word address nacked", ack_wa, 0);
        read_txn(FLT_W, 1, 8'hFF, 1);
        chk("R3 fault byte unchanged", rbytes[0], 8'h3C);
    endtask

    task automatic t_page_wrap;
        write1(msel(0, 0), 8'hFE, 8'h77);
        for (int i = 0; i < 5; i++) wbytes[i] = 8'((i + 1) * 16);
        write_txn(msel(1, 0), 8'hFE, 5);
        chk("R8 page data acknowledged", ack_data, 1);
        read_txn(msel(1, 0), 1, 8'hFE, 4);
        for (int i = 0; i < 4; i++)
            chk("R5 sequential read across wrap", rbytes[i], (i + 1) * 16);
        read_txn(msel(0, 1), 0, 8'h00, 1);
        chk("R6 current address read", rbytes[0], 8'h50);
        read_txn(msel(0, 0), 1, 8'hFE, 1);
        chk("R1 address bit 8 from select byte", rbytes[0], 8'h77);
    endtask

    task automatic t_stop_position;
        logic a;
        bus_start;
        send_byte(msel(0, 0), a);
        send_byte(8'h10, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop;
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R10 stop mid-byte aborts", rbytes[0], 8'hA5);
        bus_start;
        send_byte(msel(0, 0), a);
        send_byte(8'h10, a);
        send_byte(8'h98, a);
        bus_start;
        bus_stop;
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R10 repeated start aborts", rbytes[0], 8'hA5);
        write1(msel(0, 0), 8'h10, 8'h5B);
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R10 aligned stop commits", rbytes[0], 8'h5B);
    endtask

    task automatic t_unlock;
        write1(CTL_W, 8'hFF, 8'h5A);
        read_txn(CTL_W, 1, 8'hFF, 1);
        chk("R11 control unchanged without key", rbytes[0], 8'h00);
        write1(CTL_W, 8'hFF, 8'h06);
        write1(CTL_W, 8'hFF, 8'h5A);
        read_txn(CTL_W, 1, 8'hFF, 1);
        chk("R11 control stored after key", rbytes[0], 8'h5A);
        write1(CTL_W, 8'hFF, 8'h33);
        read_txn(CTL_W, 1, 8'hFF, 1);
        chk("R11 key consumed by one write", rbytes[0], 8'h5A);
    endtask

    task automatic t_protect;
        wp = 1'b1;
        repeat (4) @(negedge clk);
        write1(msel(0, 0), 8'h10, 8'hEE);
        chk("R9 data acknowledged under protect", ack_data, 1);
        write1(FLT_W, 8'hFF, 8'h00);
        write1(CTL_W, 8'hFF, 8'h06);
        write1(CTL_W, 8'hFF, 8'h77);
        wp = 1'b0;
        repeat (4) @(negedge clk);
        read_txn(msel(0, 0), 1, 8'h10, 1);
        chk("R9 memory unchanged under protect", rbytes[0], 8'h5B);
        read_txn(FLT_W, 1, 8'hFF, 1);
        chk("R9 fault byte unchanged under protect", rbytes[0], 8'h3C);
        read_txn(CTL_W, 1, 8'hFF, 1);
        chk("R9 control unchanged under protect", rbytes[0], 8'h5A);
    endtask

    initial begin
        t_reset_state;
        t_enable_and_store;
        t_wel_clear_on_reset;
        t_select_codes;
        t_reg_word;
        t_page_wrap;
        t_stop_position;
        t_unlock;
        t_protect;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule